// File: doc/BRIEF.md
# Double-Buffered Transmit Sequencer

This block sits between a register unit and the transmit datapath of a serial port. It manages two bytes: one waiting in a holding register and one being sent. It keeps the transmit-data-empty and transmit-end flags, and it produces a one-cycle transmit interrupt pulse and a level transmit-end interrupt. The register unit supplies write strobes for the control fields and for the transmit data byte. A frame timer reports the end of each character with a one-cycle pulse.

When a byte is written while the line is idle, it goes out at once. The block issues a load strobe and the byte to the shift register, and a start pulse to the frame timer. When a byte is written during a transfer, it is kept in the holding register and launched automatically at the next end-of-frame pulse. This lets software stream characters back to back. All outputs are registered, so each one changes on the clock edge after the event that causes it.

Top module: `txq_ctrl`

## Requirements
- R1: After reset, flag_empty and flag_end are 1, and shf_load, frm_start, irq_tx and irq_end are 0.
- R2: A control write with cw_tx_en=1 sets flag_empty and flag_end to 1 on the next cycle, and pulses irq_tx for one cycle if cw_txi_en=1.
- R3: While enabled, a data write with flag_end=1 launches the byte. On the next cycle shf_load and frm_start are 1, shf_data carries the byte, flag_end is 0, flag_empty is 1 and irq_end is 0.
- R4: irq_tx is a one-cycle pulse. It fires with every launch when the stored transmit-interrupt enable is 1, and otherwise only as in R2.
- R5: While enabled, a data write with flag_end=0 stores the byte and clears flag_empty, without a launch.
- R6: An end-of-frame pulse with flag_end=0 and flag_empty=0 launches the held byte, following the launch behaviour of R3.
- R7: An end-of-frame pulse with flag_end=0 and flag_empty=1 sets flag_end. irq_end then rises and stays high if the stored transmit-end enable is 1.
- R8: irq_end falls on a launch, or on a control write with cw_tei_en=0 or cw_tx_en=0.
- R9: A data write and an end-of-frame pulse in the same cycle with flag_end=0 launch the newly written byte.
- R10: A control write with cw_tx_en=0 returns the block to idle (both flags 1, irq_end 0) and drops any held byte. While disabled, data writes and end-of-frame pulses have no effect.
- R11: A control write takes priority: a data write or end-of-frame pulse in the same cycle is ignored.
- R12: shf_load and frm_start are always asserted together. An end-of-frame pulse while flag_end=1 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cw_we | input | 1 | Control register write strobe |
| cw_tx_en | input | 1 | Transmit enable field of the control write |
| cw_txi_en | input | 1 | Transmit interrupt enable field |
| cw_tei_en | input | 1 | Transmit-end interrupt enable field |
| dw_we | input | 1 | Transmit data write strobe |
| dw_data | input | DATA_W | Transmit data byte |
| frame_done | input | 1 | End-of-frame pulse from the frame timer |
| shf_load | output | 1 | Load strobe for the shift register |
| shf_data | output | DATA_W | Byte for the shift register |
| frm_start | output | 1 | Start pulse to the frame timer |
| flag_empty | output | 1 | Transmit-data-empty flag |
| flag_end | output | 1 | Transmit-end flag |
| irq_tx | output | 1 | Transmit interrupt, one-cycle pulse |
| irq_end | output | 1 | Transmit-end interrupt, level |

## Verification
A lost or stale holding byte shows up at the next end-of-frame pulse. Either shf_load stays low when a launch is due, or shf_data carries the wrong byte, one cycle after the pulse. A corrupted flag becomes visible on flag_empty or flag_end on the very next cycle, and it changes whether the following data write launches or queues. A wrong stored interrupt enable appears on irq_tx or irq_end on the first launch or frame end after the control write. Random interleavings of writes and frame ends, mixed with directed same-cycle collisions, expose each of these within a few cycles of the fault.

// File: rtl/txq_pkg.sv
package txq_pkg;
   typedef struct packed {
      logic tx_en;
      logic txi_en;
      logic tei_en;
   } txq_cfg_t;
endpackage

// File: rtl/txq_cfg_reg.sv
module txq_cfg_reg
   import txq_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     we,
   input  txq_cfg_t wdata,
   output txq_cfg_t cfg
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg <= '0;
      else if (we) cfg <= wdata;
   end
endmodule

// File: rtl/txq_hold.sv
module txq_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dout <= '0;
      else if (wr) dout <= din;
   end
endmodule

// File: rtl/txq_seq.sv
module txq_seq
   import txq_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cw_we,
   input  txq_cfg_t          cw_val,
   input  txq_cfg_t          cfg,
   input  logic              dw_we,
   input  logic [DATA_W-1:0] dw_data,
   input  logic              frame_done,
   input  logic [DATA_W-1:0] held,
   output logic              hold_wr,
   output logic              shf_load,
   output logic [DATA_W-1:0] shf_data,
   output logic              frm_start,
   output logic              flag_empty,
   output logic              flag_end,
   output logic              irq_tx,
   output logic              irq_end
);
   logic              launch;
   logic [DATA_W-1:0] launch_byte;
   logic              finish;

   always_comb begin
      launch      = 1'b0;
      launch_byte = dw_data;
      finish      = 1'b0;
      hold_wr     = 1'b0;
      if (!cw_we && cfg.tx_en) begin
         if (dw_we) begin
            if (flag_end || frame_done) launch = 1'b1;
            else hold_wr = 1'b1;
         end else if (frame_done && !flag_end) begin
            if (!flag_empty) begin
               launch      = 1'b1;
               launch_byte = held;
            end else begin
               finish = 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_empty <= 1'b1;
         flag_end   <= 1'b1;
         shf_load   <= 1'b0;
         frm_start  <= 1'b0;
         shf_data   <= '0;
         irq_tx     <= 1'b0;
         irq_end    <= 1'b0;
      end else begin
         shf_load  <= launch;
         frm_start <= launch;
         irq_tx    <= 1'b0;
         if (cw_we) begin
            flag_empty <= 1'b1;
            flag_end   <= 1'b1;
            irq_tx     <= cw_val.tx_en & cw_val.txi_en;
            if (!cw_val.tei_en || !cw_val.tx_en) irq_end <= 1'b0;
         end else if (launch) begin
            shf_data   <= launch_byte;
            flag_empty <= 1'b1;
            flag_end   <= 1'b0;
            irq_end    <= 1'b0;
            irq_tx     <= cfg.txi_en;
         end else if (hold_wr) begin
            flag_empty <= 1'b0;
         end else if (finish) begin
            flag_end <= 1'b1;
            irq_end  <= cfg.tei_en;
         end
      end
   end
endmodule

// File: rtl/txq_ctrl.sv
module txq_ctrl
   import txq_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cw_we,
   input  logic              cw_tx_en,
   input  logic              cw_txi_en,
   input  logic              cw_tei_en,
   input  logic              dw_we,
   input  logic [DATA_W-1:0] dw_data,
   input  logic              frame_done,
   output logic              shf_load,
   output logic [DATA_W-1:0] shf_data,
   output logic              frm_start,
   output logic              flag_empty,
   output logic              flag_end,
   output logic              irq_tx,
   output logic              irq_end
);
   localparam int MaxW = 16;

   generate
      if (DATA_W < 1 || DATA_W > MaxW) begin : g_bad_width
         $error("txq_ctrl: DATA_W out of range");
      end
   endgenerate

   txq_cfg_t          cw_val;
   txq_cfg_t          cfg;
   logic              hold_wr;
   logic [DATA_W-1:0] held;

   assign cw_val = '{tx_en: cw_tx_en, txi_en: cw_txi_en, tei_en: cw_tei_en};

   txq_cfg_reg u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cw_we),
      .wdata (cw_val),
      .cfg   (cfg)
   );

   txq_hold #(.DATA_W(DATA_W)) u_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (hold_wr),
      .din   (dw_data),
      .dout  (held)
   );

   txq_seq #(.DATA_W(DATA_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .cw_we      (cw_we),
      .cw_val     (cw_val),
      .cfg        (cfg),
      .dw_we      (dw_we),
      .dw_data    (dw_data),
      .frame_done (frame_done),
      .held       (held),
      .hold_wr    (hold_wr),
      .shf_load   (shf_load),
      .shf_data   (shf_data),
      .frm_start  (frm_start),
      .flag_empty (flag_empty),
      .flag_end   (flag_end),
      .irq_tx     (irq_tx),
      .irq_end    (irq_end)
   );
endmodule

// File: rtl/txq_ctrl_chk.sv
module txq_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic cw_we,
   input logic dw_we,
   input logic frame_done,
   input logic tx_en,
   input logic tei_en,
   input logic shf_load,
   input logic frm_start,
   input logic flag_empty,
   input logic flag_end,
   input logic irq_tx,
   input logic irq_end
);
   // R12
   load_start_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      shf_load == frm_start);
   // R3
   launch_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      shf_load |-> (!flag_end && flag_empty && !irq_end));
   // R5
   queue_clears_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dw_we && !cw_we && tx_en && !flag_end && !frame_done) |=> !flag_empty);
   // R7
   frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && !dw_we && !cw_we && tx_en && !flag_end && flag_empty)
      |=> (flag_end && irq_end == $past(tei_en)));
   // R4
   irq_tx_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_tx |-> (shf_load || $past(cw_we)));
   // R8
   irq_end_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_end |-> flag_end);
   // R10
   idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en |-> (flag_end && flag_empty && !irq_end));
endmodule

bind txq_ctrl txq_ctrl_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cw_we      (cw_we),
   .dw_we      (dw_we),
   .frame_done (frame_done),
   .tx_en      (cfg.tx_en),
   .tei_en     (cfg.tei_en),
   .shf_load   (shf_load),
   .frm_start  (frm_start),
   .flag_empty (flag_empty),
   .flag_end   (flag_end),
   .irq_tx     (irq_tx),
   .irq_end    (irq_end)
);

// File: tb/sim_txq_ctrl.sv
module sim_txq_ctrl;
   localparam int W = 8;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cw_we = 0, cw_tx_en = 0, cw_txi_en = 0, cw_tei_en = 0;
   logic dw_we = 0, frame_done = 0;
   logic [W-1:0] dw_data = '0;
   logic shf_load, frm_start, flag_empty, flag_end, irq_tx, irq_end;
   logic [W-1:0] shf_data;

   int n_chk = 0, n_bad = 0;
   logic done = 1'b0;

   // reference state
   logic m_en = 0, m_txi = 0, m_tei = 0, m_empty = 1, m_end = 1, m_irqend = 0;
   logic m_load = 0, m_irqtx = 0;
   logic [W-1:0] m_hold = '0, m_data = '0;

   always #4 clk = ~clk;

   txq_ctrl #(.DATA_W(W)) u0 (.*);

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic model(input logic cw, input logic ce, input logic ci, input logic ct,
                        input logic dw, input logic [W-1:0] d, input logic fd);
      logic st;
      logic [W-1:0] sd;
      st = 0; sd = d; m_load = 0; m_irqtx = 0;
      if (cw) begin
         m_en = ce; m_txi = ci; m_tei = ct;
         m_empty = 1; m_end = 1;
         m_irqtx = ce & ci;
         if (!ct || !ce) m_irqend = 0;
      end else if (m_en) begin
         if (dw && m_end) st = 1;
         else if (dw) begin
            m_hold = d; m_empty = 0;
            if (fd) st = 1;
         end else if (fd && !m_end) begin
            if (!m_empty) begin st = 1; sd = m_hold; end
            else begin m_end = 1; m_irqend = m_tei; end
         end
      end
      if (st) begin
         m_load = 1; m_data = sd; m_empty = 1; m_end = 0; m_irqend = 0; m_irqtx = m_txi;
      end
   endtask

   task automatic compare(input string tag);
      chk(tag, "shf_load", shf_load, m_load);
      chk(tag, "frm_start", frm_start, m_load);
      if (m_load) chk(tag, "shf_data", shf_data, m_data);
      chk(tag, "flag_empty", flag_empty, m_empty);
      chk(tag, "flag_end", flag_end, m_end);
      chk(tag, "irq_tx", irq_tx, m_irqtx);
      chk(tag, "irq_end", irq_end, m_irqend);
   endtask

   task automatic step(input logic cw, input logic ce, input logic ci, input logic ct,
                       input logic dw, input logic [W-1:0] d, input logic fd,
                       input string tag);
      cw_we = cw; cw_tx_en = ce; cw_txi_en = ci; cw_tei_en = ct;
      dw_we = dw; dw_data = d; frame_done = fd;
      model(cw, ce, ci, ct, dw, d, fd);
      @(posedge clk);
      @(negedge clk);
      cw_we = 0; dw_we = 0; frame_done = 0;
      compare(tag);
   endtask

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      compare("R1");
      step(1,1,1,1, 0,8'h00,0, "R2");
      step(0,0,0,0, 1,8'hA5,0, "R3");
      step(0,0,0,0, 1,8'h3C,0, "R5");
      step(0,0,0,0, 0,8'h00,1, "R6");
      step(0,0,0,0, 0,8'h00,1, "R7");
      step(0,0,0,0, 0,8'h00,1, "R12");
      step(1,1,0,0, 0,8'h00,0, "R8");
      step(0,0,0,0, 1,8'h11,0, "R3");
      step(0,0,0,0, 1,8'h22,1, "R9");
      step(1,1,1,1, 1,8'h5A,1, "R11");
      step(0,0,0,0, 1,8'h33,0, "R4");
      step(0,0,0,0, 1,8'h44,0, "R5");
      step(1,0,0,1, 0,8'h00,0, "R10");
      step(0,0,0,0, 0,8'h00,1, "R10");
      step(0,0,0,0, 1,8'h77,0, "R10");
      step(1,1,1,1, 0,8'h00,0, "R2");
      for (int i = 0; i < 4000; i++) begin
         logic cw, ce;
         cw = ($urandom_range(0, 39) == 0);
         ce = ($urandom_range(0, 5) != 0);
         step(cw, ce, 1'($urandom), 1'($urandom),
              ($urandom_range(0, 2) == 0), W'($urandom), ($urandom_range(0, 3) == 0),
              "R3/R4/R5/R6/R7/R8/R9/R12");
      end
      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired actual=1 expected=0");
      end
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule